// File: doc/BRIEF.md
# Integer MLP Classifier with Argmax Character Output

This block runs inference for a three-layer perceptron using integer arithmetic only. It holds an input vector, all weights and all biases in one internal word store, which is filled through a valid/ready load port. A single multiply-accumulate unit evaluates the layers in sequence: first hidden layer, then second hidden layer, then output layer. Each hidden neuron is rectified and then rescaled by the weight scale factor (default 10,000) before it feeds the next layer. The output layer is not normalised. The winning class is the index of the largest raw output sum, and that index is also delivered as an ASCII character.

Software or a loader writes the store, pulses `start` and waits for `done`. The load port is back-pressured for the whole inference: `ld_ready` is low while `busy` is high, so the store cannot change under a running evaluation. When idle, one word is accepted on every cycle in which `ld_valid` and `ld_ready` are both high. There is no back-pressure on the result. `done` is a single-cycle strobe, and `class_idx` and `char_code` hold their values until the next result.

Top module: `mlp_classifier`

## Requirements
- R1: Store layout, word address order. Input words sit at 0..N_IN-1. Then come the layer-1 weights (neuron-major, N_H1*N_IN words), the layer-1 biases (N_H1), the layer-2 weights (N_H2*N_H1), the layer-2 biases (N_H2), the output weights (N_OUT*N_H2) and the output biases (N_OUT). All words are signed 32-bit. When idle, `ld_ready` is 1 and a word is written on every cycle with `ld_valid` high.
- R2: While `busy` is high, `ld_ready` is 0 and an offered word is not written, so it has no effect on the result.
- R3: A one-cycle `start` sampled while idle begins an inference. `done` is high for exactly one cycle, T = N_H1*(N_IN+1) + N_H2*(N_H1+1) + N_OUT*(N_H2+1) cycles after the edge that sampled `start`, and `busy` is low from that cycle on.
- R4: `start` sampled while `busy` is high is ignored. It produces no extra `done` and no restart, and the first run's timing is unchanged.
- R5: A hidden neuron's value is the bias plus the dot product of its weights with the previous layer's values. A negative value becomes 0. A non-negative value is divided by SCALE, truncated, and saturated at 2^31-1.
- R6: The class is the index of the largest output-layer sum (bias plus dot product, no rectification). When several sums are equal, the lowest index wins.
- R7: `char_code` maps the class in order: 0-9 give '0'-'9' (0x30-0x39), 10-35 give 'A'-'Z' (0x41-0x5A), and 36-61 give 'a'-'z' (0x61-0x7A).
- R8: After reset, `busy`, `done`, `class_idx` and `char_code` are 0 and `ld_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an inference |
| busy | output | 1 | High while an inference is in progress |
| done | output | 1 | One-cycle strobe; result is valid |
| class_idx | output | $clog2(N_OUT) | Winning class index |
| char_code | output | 8 | ASCII character of the winning class |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word accepted (idle only) |
| ld_addr | input | $clog2(DEPTH) | Store word address |
| ld_data | input | 32 | Signed store word |

## Verification
The comparison for the last output neuron and the delivery of the result happen in the same cycle. The final index must therefore be resolved from the current sum and the best sum so far together. This is provoked by giving the winning bias to index 61, and also by a tie whose second member is the last neuron; each case is judged on `class_idx` and `char_code`. A second coincidence is provoked by offering a load word and re-pulsing `start` in the middle of a run. The bench judges it by an unchanged latency, a single `done` and a class computed from the untouched store.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  localparam int WORD_W = 32;
  localparam int ACC_W  = 48;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HID1 = 2'd1,
    ST_HID2 = 2'd2,
    ST_OUTL = 2'd3
  } stage_e;

  // class index to printable character: digits, upper case, lower case
  function automatic logic [7:0] class_char(input int unsigned idx);
    if (idx < 10)      return 8'(32'd48 + idx);
    else if (idx < 36) return 8'(32'd55 + idx);
    else               return 8'(32'd61 + idx);
  endfunction
endpackage

// File: rtl/mlp_store.sv
module mlp_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic signed [31:0]       wr_data,
  input  logic [AW-1:0]            x_addr,
  output logic signed [31:0]       x_word,
  input  logic [AW-1:0]            p_addr,
  output logic signed [31:0]       p_word
);
  logic signed [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign x_word = mem[x_addr];
  assign p_word = mem[p_addr];
endmodule

// File: rtl/mlp_seq.sv
module mlp_seq
  import mlp_pkg::*;
#(
  parameter int N_IN  = 16,
  parameter int N_H1  = 8,
  parameter int N_H2  = 8,
  parameter int N_OUT = 62,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output stage_e        stage,
  output logic [IW-1:0] nrn,
  output logic [IW-1:0] kk,
  output logic          bias_cyc
);
  int fan_in, fan_out;

  always_comb begin
    case (stage)
      ST_HID1: begin fan_in = N_IN; fan_out = N_H1;  end
      ST_HID2: begin fan_in = N_H1; fan_out = N_H2;  end
      ST_OUTL: begin fan_in = N_H2; fan_out = N_OUT; end
      default: begin fan_in = 1;    fan_out = 1;     end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage    <= ST_IDLE;
      nrn      <= '0;
      kk       <= '0;
      bias_cyc <= 1'b0;
    end else if (stage == ST_IDLE) begin
      if (start) begin
        stage    <= ST_HID1;
        nrn      <= '0;
        kk       <= '0;
        bias_cyc <= 1'b0;
      end
    end else if (!bias_cyc) begin
      if (int'(kk) == fan_in - 1) bias_cyc <= 1'b1;
      else                        kk <= kk + 1'b1;
    end else begin
      bias_cyc <= 1'b0;
      kk       <= '0;
      if (int'(nrn) == fan_out - 1) begin
        nrn   <= '0;
        stage <= (stage == ST_OUTL) ? ST_IDLE : stage_e'(stage + 2'd1);
      end else begin
        nrn <= nrn + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mlp_mac.sv
module mlp_mac
  import mlp_pkg::*;
#(
  parameter int SCALE = 10000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_en,
  input  logic                    bias_en,
  input  logic signed [31:0]      x_op,
  input  logic signed [31:0]      w_op,
  output logic signed [ACC_W-1:0] sum,
  output logic signed [31:0]      hid_act
);
  localparam logic signed [ACC_W-1:0] SAT_MAX = ACC_W'(64'sd2147483647);

  logic signed [ACC_W-1:0] acc;
  logic signed [63:0]      prod;
  logic signed [ACC_W-1:0] quot;

  assign prod = x_op * w_op;
  assign sum  = acc + ACC_W'(w_op);   // during the bias cycle w_op is the bias
  assign quot = sum / ACC_W'(SCALE);

  always_comb begin
    if (sum < 0)             hid_act = '0;
    else if (quot > SAT_MAX) hid_act = 32'sh7fffffff;
    else                     hid_act = quot[31:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (bias_en) acc <= '0;
    else if (acc_en)  acc <= acc + ACC_W'(prod);
  end
endmodule

// File: rtl/mlp_classifier.sv
module mlp_classifier
  import mlp_pkg::*;
#(
  parameter int N_IN  = 16,
  parameter int N_H1  = 8,
  parameter int N_H2  = 8,
  parameter int N_OUT = 62,
  parameter int SCALE = 10000,
  localparam int OFF_W1 = N_IN,
  localparam int OFF_B1 = OFF_W1 + N_H1 * N_IN,
  localparam int OFF_W2 = OFF_B1 + N_H1,
  localparam int OFF_B2 = OFF_W2 + N_H2 * N_H1,
  localparam int OFF_W3 = OFF_B2 + N_H2,
  localparam int OFF_B3 = OFF_W3 + N_OUT * N_H2,
  localparam int DEPTH  = OFF_B3 + N_OUT,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(N_OUT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [CW-1:0]      class_idx,
  output logic [7:0]         char_code,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [AW-1:0]      ld_addr,
  input  logic signed [31:0] ld_data
);
  localparam int MAXA = (N_IN > N_H1) ? N_IN : N_H1;
  localparam int MAXB = (N_H2 > N_OUT) ? N_H2 : N_OUT;
  localparam int MAXN = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int IW   = $clog2(MAXN);
  localparam int H1W  = $clog2(N_H1);
  localparam int H2W  = $clog2(N_H2);

  stage_e                  stage;
  logic [IW-1:0]           nrn, kk;
  logic                    bias_cyc;
  logic [AW-1:0]           x_addr, p_addr;
  logic signed [31:0]      x_word, p_word, x_op, hid_act;
  logic signed [ACC_W-1:0] sum, best_val;
  logic [CW-1:0]           best_idx, final_idx;
  logic                    take;
  logic signed [31:0]      h1 [N_H1];
  logic signed [31:0]      h2 [N_H2];
  int                      fin, wbase, bbase;

  assign busy     = (stage != ST_IDLE);
  assign ld_ready = !busy;

  mlp_seq #(.N_IN(N_IN), .N_H1(N_H1), .N_H2(N_H2), .N_OUT(N_OUT), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .stage(stage), .nrn(nrn), .kk(kk), .bias_cyc(bias_cyc)
  );

  mlp_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk),
    .wr_en(ld_valid && ld_ready && (int'(ld_addr) < DEPTH)),
    .wr_addr(ld_addr), .wr_data(ld_data),
    .x_addr(x_addr), .x_word(x_word),
    .p_addr(p_addr), .p_word(p_word)
  );

  mlp_mac #(.SCALE(SCALE)) u_mac (
    .clk(clk), .rst_n(rst_n),
    .acc_en(busy && !bias_cyc), .bias_en(busy && bias_cyc),
    .x_op(x_op), .w_op(p_word), .sum(sum), .hid_act(hid_act)
  );

  // address generation and operand selection per stage
  always_comb begin
    case (stage)
      ST_HID1: begin fin = N_IN; wbase = OFF_W1; bbase = OFF_B1; x_op = x_word;           end
      ST_HID2: begin fin = N_H1; wbase = OFF_W2; bbase = OFF_B2; x_op = h1[kk[H1W-1:0]]; end
      ST_OUTL: begin fin = N_H2; wbase = OFF_W3; bbase = OFF_B3; x_op = h2[kk[H2W-1:0]]; end
      default: begin fin = 1;    wbase = 0;      bbase = 0;      x_op = '0;               end
    endcase
    x_addr = AW'(kk);
    p_addr = bias_cyc ? AW'(bbase + int'(nrn))
                      : AW'(wbase + int'(nrn) * fin + int'(kk));
  end

  always_ff @(posedge clk) begin
    if (stage == ST_HID1 && bias_cyc) h1[nrn[H1W-1:0]] <= hid_act;
    if (stage == ST_HID2 && bias_cyc) h2[nrn[H2W-1:0]] <= hid_act;
  end

  // running argmax, strict compare keeps the lowest index on ties
  assign take      = (nrn == '0) || (sum > best_val);
  assign final_idx = take ? nrn[CW-1:0] : best_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_val  <= '0;
      best_idx  <= '0;
      class_idx <= '0;
      char_code <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (stage == ST_OUTL && bias_cyc) begin
        if (take) begin
          best_val <= sum;
          best_idx <= nrn[CW-1:0];
        end
        if (int'(nrn) == N_OUT - 1) begin
          done      <= 1'b1;
          class_idx <= final_idx;
          char_code <= class_char(32'(final_idx));
        end
      end
    end
  end
endmodule

// File: rtl/mlp_classifier_chk.sv
module mlp_classifier_chk #(
  parameter int N_IN  = 16,
  parameter int N_H1  = 8,
  parameter int N_H2  = 8,
  parameter int N_OUT = 62,
  localparam int CW   = $clog2(N_OUT)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] class_idx,
  input logic [7:0]    char_code
);
  localparam int TOTAL = N_H1 * (N_IN + 1) + N_H2 * (N_H1 + 1) + N_OUT * (N_H2 + 1);

  int busy_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) busy_cnt <= 0;
    else        busy_cnt <= busy ? busy_cnt + 1 : 0;
  end

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == TOTAL && !busy));
  a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> busy);
  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(class_idx) < N_OUT));
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || ($stable(class_idx) && $stable(char_code))));
  a_r7_digit_char: assert property (@(posedge clk) disable iff (!rst_n)
    (done && int'(class_idx) < 10) |-> (char_code >= 8'h30 && char_code <= 8'h39));
  a_r7_letter_char: assert property (@(posedge clk) disable iff (!rst_n)
    (done && int'(class_idx) >= 10) |-> ((char_code >= 8'h41 && char_code <= 8'h5A) ||
                                          (char_code >= 8'h61 && char_code <= 8'h7A)));
endmodule

bind mlp_classifier mlp_classifier_chk #(
  .N_IN(N_IN), .N_H1(N_H1), .N_H2(N_H2), .N_OUT(N_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .class_idx(class_idx), .char_code(char_code)
);

// File: tb/tb_mlp_classifier.sv
module tb_mlp_classifier;
  localparam int N_IN = 16, N_H1 = 8, N_H2 = 8, N_OUT = 62, SCALE = 10000;
  localparam int W1 = N_IN, B1 = W1 + N_H1 * N_IN, W2 = B1 + N_H1, B2 = W2 + N_H2 * N_H1;
  localparam int W3 = B2 + N_H2, B3 = W3 + N_OUT * N_H2, DEPTH = B3 + N_OUT;
  localparam int AW = $clog2(DEPTH), CW = $clog2(N_OUT);
  localparam int T_RUN = N_H1 * (N_IN + 1) + N_H2 * (N_H1 + 1) + N_OUT * (N_H2 + 1);
  localparam string CHARS = "0123456789ABCDEFGHIJKLMNOPQRSTUVWXYZabcdefghijklmnopqrstuvwxyz";

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, ld_valid = 1'b0, ld_ready;
  logic [CW-1:0] class_idx;
  logic [7:0] char_code;
  logic [AW-1:0] ld_addr = '0;
  logic signed [31:0] ld_data = '0;

  int n_tests = 0, n_fail = 0;
  int mem_img [DEPTH];

  always #5 clk = ~clk;

  mlp_classifier #(.N_IN(N_IN), .N_H1(N_H1), .N_H2(N_H2), .N_OUT(N_OUT), .SCALE(SCALE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .class_idx(class_idx), .char_code(char_code),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint hidden(input longint acc);
    longint q;
    if (acc < 0) return 0;
    q = acc / SCALE;
    return (q > 64'sd2147483647) ? 64'sd2147483647 : q;
  endfunction

  function automatic int ref_class();
    longint a1 [N_H1];
    longint a2 [N_H2];
    longint acc, best;
    int bi;
    for (int j = 0; j < N_H1; j++) begin
      acc = longint'(mem_img[B1 + j]);
      for (int i = 0; i < N_IN; i++) acc += longint'(mem_img[W1 + j * N_IN + i]) * longint'(mem_img[i]);
      a1[j] = hidden(acc);
    end
    for (int j = 0; j < N_H2; j++) begin
      acc = longint'(mem_img[B2 + j]);
      for (int i = 0; i < N_H1; i++) acc += longint'(mem_img[W2 + j * N_H1 + i]) * a1[i];
      a2[j] = hidden(acc);
    end
    best = 0; bi = 0;
    for (int j = 0; j < N_OUT; j++) begin
      acc = longint'(mem_img[B3 + j]);
      for (int i = 0; i < N_H2; i++) acc += longint'(mem_img[W3 + j * N_H2 + i]) * a2[i];
      if (j == 0 || acc > best) begin best = acc; bi = j; end
    end
    return bi;
  endfunction

  task automatic wr_word(input int addr, input int val);
    mem_img[addr] = val;
    ld_valid = 1'b1; ld_addr = AW'(addr); ld_data = val;
    @(negedge clk);
  endtask

  task automatic load_all();
    for (int a = 0; a < DEPTH; a++) wr_word(a, mem_img[a]);
    ld_valid = 1'b0;
  endtask

  task automatic fill_random();
    for (int a = 0; a < N_IN; a++) mem_img[a] = int'($urandom_range(255, 0));
    for (int a = N_IN; a < DEPTH; a++) mem_img[a] = int'($urandom_range(60000, 0)) - 30000;
    for (int j = 0; j < N_H1; j++) mem_img[B1 + j] = int'($urandom_range(600000, 0)) - 300000;
    for (int j = 0; j < N_H2; j++) mem_img[B2 + j] = int'($urandom_range(600000, 0)) - 300000;
  endtask

  // output weights zero, output biases decide the class directly
  task automatic bias_only(input int win_a, input int win_b);
    for (int a = W3; a < B3; a++) mem_img[a] = 0;
    for (int j = 0; j < N_OUT; j++) mem_img[B3 + j] = -1000 - j;
    mem_img[B3 + win_a] = 5000;
    mem_img[B3 + win_b] = 5000;
  endtask

  task automatic run_inf(input string req, input int exp_idx, input bit poke_start, input bit poke_wr);
    int cyc;
    int extra_done;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < T_RUN + 50) begin
      if (poke_start && cyc == 5) start = 1'b1;
      if (poke_start && cyc == 6) start = 1'b0;
      if (poke_wr && cyc == 3) begin
        ld_valid = 1'b1; ld_addr = AW'(B3 + exp_idx + 1); ld_data = 32'sh7fffffff;
      end
      if (poke_wr && cyc == 4) begin
        check(ld_ready == 1'b0, "R2 ready low while busy", ld_ready, 0);
        ld_valid = 1'b0;
      end
      @(negedge clk); cyc++;
    end
    check(done == 1'b1, "R3 done seen", done, 1);
    check(cyc == T_RUN, {req, " R3 latency"}, cyc, T_RUN);
    check(int'(class_idx) == exp_idx, {req, " R6 class"}, class_idx, exp_idx);
    check(char_code == 8'(CHARS[exp_idx]), {req, " R7 char"}, char_code, CHARS[exp_idx]);
    extra_done = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done || busy) extra_done++;
    end
    check(extra_done == 0, {req, " R3/R4 single done, no restart"}, extra_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R8 reset busy/done", {busy, done}, 0);
    check(class_idx == '0 && char_code == 8'h00, "R8 reset outputs", char_code, 0);
    check(ld_ready == 1'b1, "R8/R1 ready when idle", ld_ready, 1);

    // R1/R5/R6: random networks through the full load map
    for (int r = 0; r < 6; r++) begin
      fill_random();
      load_all();
      run_inf("R1 R5 random", ref_class(), 1'b0, 1'b0);
    end

    // R5: all layer-1 sums strongly negative, rectified to zero
    fill_random();
    for (int j = 0; j < N_H1; j++) mem_img[B1 + j] = -2000000000;
    load_all();
    run_inf("R5 relu zero", ref_class(), 1'b0, 1'b0);

    // R6: tie between index 7 and 20 -> 7; all equal -> 0
    bias_only(7, 20); load_all();
    run_inf("R6 tie", 7, 1'b0, 1'b0);
    for (int j = 0; j < N_OUT; j++) wr_word(B3 + j, 123);
    ld_valid = 1'b0;
    run_inf("R6 all equal", 0, 1'b0, 1'b0);

    // R7: character boundaries, incl. last neuron winning and tie with the last neuron
    begin
      int picks [5] = '{9, 10, 35, 36, 61};
      foreach (picks[p]) begin
        bias_only(picks[p], picks[p]); load_all();
        run_inf("R7 boundary", picks[p], 1'b0, 1'b0);
      end
    end
    bias_only(40, 61); load_all();
    run_inf("R6 tie with last", 40, 1'b0, 1'b0);

    // R2/R4: write offered and start re-pulsed mid-run
    bias_only(30, 30); load_all();
    run_inf("R2 R4 mid-run", 30, 1'b1, 1'b1);
    run_inf("R2 store unchanged", 30, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule